// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block is the command half of a simple MMC/SD host. It holds the registers software uses to launch a card command (index, argument and control flags), sends each launched command to a card-side engine over a start-strobe interface, and captures what comes back. A reply may be a 32-bit word, a 128-bit word, nothing at all, or something malformed. The block also logs which command was answered, keeps a status word that software clears by writing ones, and drives a level interrupt from that status and an enable mask.

Software programs the argument, then writes the command register with the enable flag set. The block pulses `cmdStart` with the index and argument and waits. It stops waiting when the card engine pulses `cardDone` or when a fixed cycle window runs out. A soft reset is requested through a flag in the command register. The data-control, length, power and clock registers are plain storage for the neighbouring data path. The bus-capability, FIFO-depth and revision registers return constants.

Top module: `sdcmd_host`

Register offsets (byte addresses, 32-bit access only): status 0x00 (read), status clear 0x04 (write), interrupt enable 0x08, command 0x0C, argument 0x10, answered-command log 0x14, response words 0 to 3 at 0x18, 0x1C, 0x20 and 0x24, data control 0x28, data length 0x2C, power 0x30, clock 0x34, bus capability 0x38, FIFO depth 0x3C, revision 0x40.

## Requirements
- R1: A write to the command register (0x0C) with bit 9 (enable) set and bit 10 clear, while no command is outstanding, raises `cmdStart` for exactly one cycle, in the cycle after the write. During that pulse `cmdIndex` carries bits 5:0 of the written value and `cmdArg` carries the argument register (0x10).
- R2: The enable bit self-clears: the command register reads back the written value with bit 9 zero. Launching a command clears status bits 2, 4 and 6.
- R3: An enable write made while a command is outstanding stores the new fields but launches nothing. The outstanding command's index is the one that gets logged.
- R4: When bit 6 (expect response) of the launched command is clear, a `cardDone` pulse sets status bit 6 (command sent).
- R5: When a response is expected and `cardDone` comes with `cardRspLen` = 1 (32-bit), response word 0 takes `cardRsp[127:96]`, response words 1, 2 and 3 read zero, and status bit 4 is set.
- R6: When a response is expected and `cardRspLen` = 2 (128-bit), word 3 takes `cardRsp[127:96]`, word 2 takes `[95:64]`, word 1 takes `[63:32]`, and word 0 takes `[31:0]` with bit 0 forced to zero. Status bit 4 is set. This holds even if bit 7 (long) was not requested.
- R7: On a valid response, the log register (0x14) holds the answered index in bits 5:0 and bit 8 of the launched command (application command) in bit 6.
- R8: When a response is expected and `cardRspLen` is 0 (none) or 3 (malformed), or is 1 while bit 7 was set, status bit 2 is set and the response words and log are unchanged.
- R9: If no `cardDone` arrives within TIMEOUT_CYCLES cycles, counted from the `cmdStart` cycle, status bit 2 is set and the block becomes idle. A later `cardDone` is ignored.
- R10: A write to the status clear register (0x04) clears each status bit set in the written value ANDed with 0x14FF. A status bit set on the same edge stays set.
- R11: `irq` is high exactly when status AND interrupt enable (0x08) is nonzero.
- R12: A command write with bit 10 set launches nothing and abandons any outstanding command. It zeroes the command, argument, response words, log, data control, length, interrupt enable, power and clock registers. It clears status bits 11 and 12 and sets bits 8 and 9, leaving the other status bits as they were. After hardware reset the status reads 0x300 and all other writable registers read zero.
- R13: Bus capability reads 0x09, FIFO depth reads 0x10 and revision reads 0x00030300. Undefined offsets read zero. Writes to undefined or read-only offsets have no effect.
- R14: Data control, data length, power and clock store and return any 32-bit value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| irq | output | 1 | Level interrupt |
| cmdStart | output | 1 | One-cycle command launch strobe |
| cmdIndex | output | 6 | Index of the launched command |
| cmdArg | output | 32 | Argument of the launched command |
| cardDone | input | 1 | Card engine reply strobe |
| cardRspLen | input | 2 | Reply length: 0 none, 1 32-bit, 2 128-bit, 3 malformed |
| cardRsp | input | 128 | Reply bits, first received in bit 127 |

## Verification
The hardest situations to reach are collisions on one clock edge. These include a card reply landing in the same cycle as a status-clear write, a soft reset arriving while a command is outstanding, and a reply arriving only after the window has closed. The stimulus drives `cardDone` in the same cycle as a register write. It holds a command unanswered past TIMEOUT_CYCLES and then sends a stale reply. It also issues a soft reset between launch and reply, then checks that the late reply leaves every register untouched. A behavioural model run every clock confirms `irq`, `cmdStart` and the read data for the address on the bus.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int WORD_W = 32;
  localparam int RSP_WORDS = 4;
  localparam int RSP_W = WORD_W * RSP_WORDS;

  localparam int OFF_STATUS  = 'h00;
  localparam int OFF_STATCLR = 'h04;
  localparam int OFF_INTEN   = 'h08;
  localparam int OFF_CMD     = 'h0C;
  localparam int OFF_ARG     = 'h10;
  localparam int OFF_RIDX    = 'h14;
  localparam int OFF_RSP0    = 'h18;
  localparam int OFF_DCTL    = 'h28;
  localparam int OFF_DLEN    = 'h2C;
  localparam int OFF_PWR     = 'h30;
  localparam int OFF_CLK     = 'h34;
  localparam int OFF_BUSCAP  = 'h38;
  localparam int OFF_FIFO    = 'h3C;
  localparam int OFF_REV     = 'h40;

  localparam int CF_EXPECT = 6;
  localparam int CF_LONG   = 7;
  localparam int CF_APP    = 8;
  localparam int CF_EN     = 9;
  localparam int CF_RST    = 10;
  localparam int CF_W      = CF_RST + 1;

  localparam int ST_TIMEOUT = 2;
  localparam int ST_RSP     = 4;
  localparam int ST_SENT    = 6;

  localparam logic [WORD_W-1:0] STATUS_READY  = 32'h0000_0300;
  localparam logic [WORD_W-1:0] STATUS_SRCLR  = 32'h0000_1800;
  localparam logic [WORD_W-1:0] CLEAR_MASK    = 32'h0000_14FF;
  localparam logic [WORD_W-1:0] ISSUE_CLEAR   = 32'h0000_0054;
  localparam logic [WORD_W-1:0] BUSCAP_VALUE  = 32'h0000_0009;
  localparam logic [WORD_W-1:0] FIFO_VALUE    = 32'h0000_0010;
  localparam logic [WORD_W-1:0] REV_VALUE     = 32'h0003_0300;

  typedef enum logic [1:0] {
    RLEN_NONE  = 2'd0,
    RLEN_SHORT = 2'd1,
    RLEN_LONG  = 2'd2,
    RLEN_BAD   = 2'd3
  } rspLen_e;

  typedef struct packed {
    logic issue;
    logic abort;
    logic storeShort;
    logic storeLong;
    logic setSent;
    logic setTimeout;
  } cmdStrobe_t;
endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [CF_W-1:0]   cmdField,
  input  logic [WORD_W-1:0] argValue,
  input  logic              cardDone,
  input  logic [1:0]        cardRspLen,
  output cmdStrobe_t        strobe,
  output logic              cmdStart,
  output logic [5:0]        cmdIndex,
  output logic [WORD_W-1:0] cmdArg,
  output logic              issuedApp
);
  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  typedef enum logic {IDLE, WAIT} state_e;

  state_e     stateQ;
  logic [CNT_W-1:0] waitCnt;
  logic       expectQ, longQ;
  logic       softRst, goIssue, badRsp, windowEnd;
  rspLen_e    lenCode;

  assign lenCode   = rspLen_e'(cardRspLen);
  assign softRst   = cmdWrite && cmdField[CF_RST];
  assign goIssue   = cmdWrite && !cmdField[CF_RST] && cmdField[CF_EN] && (stateQ == IDLE);
  assign windowEnd = (waitCnt == CNT_LAST);
  assign badRsp    = (lenCode == RLEN_NONE) || (lenCode == RLEN_BAD) ||
                     ((lenCode == RLEN_SHORT) && longQ);

  always_comb begin
    strobe = '0;
    strobe.abort = softRst;
    strobe.issue = goIssue;
    if (stateQ == WAIT && !softRst) begin
      if (cardDone) begin
        if (!expectQ)                  strobe.setSent    = 1'b1;
        else if (badRsp)               strobe.setTimeout = 1'b1;
        else if (lenCode == RLEN_LONG) strobe.storeLong  = 1'b1;
        else                           strobe.storeShort = 1'b1;
      end else if (windowEnd) begin
        strobe.setTimeout = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= IDLE;
      waitCnt   <= '0;
      cmdStart  <= 1'b0;
      cmdIndex  <= '0;
      cmdArg    <= '0;
      issuedApp <= 1'b0;
      expectQ   <= 1'b0;
      longQ     <= 1'b0;
    end else begin
      cmdStart <= goIssue;
      if (softRst) begin
        stateQ <= IDLE;
      end else if (goIssue) begin
        stateQ    <= WAIT;
        waitCnt   <= '0;
        cmdIndex  <= cmdField[5:0];
        cmdArg    <= argValue;
        issuedApp <= cmdField[CF_APP];
        expectQ   <= cmdField[CF_EXPECT];
        longQ     <= cmdField[CF_LONG];
      end else if (stateQ == WAIT) begin
        if (cardDone || windowEnd) stateQ <= IDLE;
        else                       waitCnt <= waitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  cmdStrobe_t        strobe,
  input  logic [RSP_W-1:0]  cardRsp,
  input  logic [5:0]        issuedIdx,
  input  logic              issuedApp,
  output logic [WORD_W-1:0] regRdata,
  output logic              irq,
  output logic              cmdWrite,
  output logic [WORD_W-1:0] argValue
);
  logic [WORD_W-1:0] cmdQ, argQ, ridxQ, dctlQ, dlenQ, intenQ, pwrQ, clkQ;
  logic [WORD_W-1:0] statusQ, statusNext;
  logic [WORD_W-1:0] rspQ [RSP_WORDS];
  logic wrClr, wrInten, wrArg, wrDctl, wrDlen, wrPwr, wrClk;

  assign cmdWrite = regWr && (regAddr == ADDR_W'(OFF_CMD));
  assign wrClr    = regWr && (regAddr == ADDR_W'(OFF_STATCLR));
  assign wrInten  = regWr && (regAddr == ADDR_W'(OFF_INTEN));
  assign wrArg    = regWr && (regAddr == ADDR_W'(OFF_ARG));
  assign wrDctl   = regWr && (regAddr == ADDR_W'(OFF_DCTL));
  assign wrDlen   = regWr && (regAddr == ADDR_W'(OFF_DLEN));
  assign wrPwr    = regWr && (regAddr == ADDR_W'(OFF_PWR));
  assign wrClk    = regWr && (regAddr == ADDR_W'(OFF_CLK));
  assign argValue = argQ;
  assign irq      = |(statusQ & intenQ);

  // Response words: one register per word, long replies land highest-first.
  for (genvar w = 0; w < RSP_WORDS; w++) begin : gRsp
    logic [WORD_W-1:0] longVal, shortVal;
    if (w == 0) begin : gLow
      assign longVal  = cardRsp[WORD_W-1:0] & ~WORD_W'(1);
      assign shortVal = cardRsp[RSP_W-1 -: WORD_W];
    end else begin : gHigh
      assign longVal  = cardRsp[w*WORD_W +: WORD_W];
      assign shortVal = '0;
    end
    always_ff @(posedge clk) begin
      if (!rstN || strobe.abort) rspQ[w] <= '0;
      else if (strobe.storeLong)  rspQ[w] <= longVal;
      else if (strobe.storeShort) rspQ[w] <= shortVal;
    end
  end

  always_comb begin
    statusNext = statusQ;
    if (wrClr)        statusNext = statusNext & ~(regWdata & CLEAR_MASK);
    if (strobe.issue) statusNext = statusNext & ~ISSUE_CLEAR;
    if (strobe.setTimeout) statusNext[ST_TIMEOUT] = 1'b1;
    if (strobe.storeShort || strobe.storeLong) statusNext[ST_RSP] = 1'b1;
    if (strobe.setSent) statusNext[ST_SENT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             statusQ <= STATUS_READY;
    else if (strobe.abort) statusQ <= (statusQ & ~STATUS_SRCLR) | STATUS_READY;
    else                   statusQ <= statusNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.abort) begin
      cmdQ   <= '0;
      argQ   <= '0;
      ridxQ  <= '0;
      dctlQ  <= '0;
      dlenQ  <= '0;
      intenQ <= '0;
      pwrQ   <= '0;
      clkQ   <= '0;
    end else begin
      if (cmdWrite) cmdQ   <= regWdata & ~(WORD_W'(1) << CF_EN);
      if (wrArg)    argQ   <= regWdata;
      if (wrDctl)   dctlQ  <= regWdata;
      if (wrDlen)   dlenQ  <= regWdata;
      if (wrInten)  intenQ <= regWdata;
      if (wrPwr)    pwrQ   <= regWdata;
      if (wrClk)    clkQ   <= regWdata;
      if (strobe.storeShort || strobe.storeLong)
        ridxQ <= {25'd0, issuedApp, issuedIdx};
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(OFF_STATUS):    regRdata = statusQ;
      ADDR_W'(OFF_INTEN):     regRdata = intenQ;
      ADDR_W'(OFF_CMD):       regRdata = cmdQ;
      ADDR_W'(OFF_ARG):       regRdata = argQ;
      ADDR_W'(OFF_RIDX):      regRdata = ridxQ;
      ADDR_W'(OFF_RSP0):      regRdata = rspQ[0];
      ADDR_W'(OFF_RSP0 + 4):  regRdata = rspQ[1];
      ADDR_W'(OFF_RSP0 + 8):  regRdata = rspQ[2];
      ADDR_W'(OFF_RSP0 + 12): regRdata = rspQ[3];
      ADDR_W'(OFF_DCTL):      regRdata = dctlQ;
      ADDR_W'(OFF_DLEN):      regRdata = dlenQ;
      ADDR_W'(OFF_PWR):       regRdata = pwrQ;
      ADDR_W'(OFF_CLK):       regRdata = clkQ;
      ADDR_W'(OFF_BUSCAP):    regRdata = BUSCAP_VALUE;
      ADDR_W'(OFF_FIFO):      regRdata = FIFO_VALUE;
      ADDR_W'(OFF_REV):       regRdata = REV_VALUE;
      default:                regRdata = '0;
    endcase
  end
endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              cmdStart,
  output logic [5:0]        cmdIndex,
  output logic [31:0]       cmdArg,
  input  logic              cardDone,
  input  logic [1:0]        cardRspLen,
  input  logic [127:0]      cardRsp
);
  cmdStrobe_t        strobe;
  logic              cmdWrite, issuedApp;
  logic [WORD_W-1:0] argValue;

  sdcmd_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrite   (cmdWrite),
    .cmdField   (regWdata[CF_W-1:0]),
    .argValue   (argValue),
    .cardDone   (cardDone),
    .cardRspLen (cardRspLen),
    .strobe     (strobe),
    .cmdStart   (cmdStart),
    .cmdIndex   (cmdIndex),
    .cmdArg     (cmdArg),
    .issuedApp  (issuedApp)
  );

  sdcmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .strobe    (strobe),
    .cardRsp   (cardRsp),
    .issuedIdx (cmdIndex),
    .issuedApp (issuedApp),
    .regRdata  (regRdata),
    .irq       (irq),
    .cmdWrite  (cmdWrite),
    .argValue  (argValue)
  );
endmodule

// File: rtl/sdcmd_host_chk.sv
module sdcmd_host_chk
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              irq,
  input logic              cmdStart,
  input logic [5:0]        cmdIndex,
  input logic [31:0]       cmdArg
);
  logic cmdWr, enWr;
  assign cmdWr = regWr && (regAddr == ADDR_W'(OFF_CMD));
  assign enWr  = regWr && (regAddr == ADDR_W'(OFF_INTEN));

  AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart); // R1

  AST_LAUNCH_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> ($stable(cmdIndex) && $stable(cmdArg))); // R1

  AST_ENABLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFF_CMD)) |-> !regRdata[CF_EN]); // R2

  AST_IRQ_OFF_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && regWdata == 32'd0) |=> !irq); // R11

  AST_SOFT_RESET_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWdata[CF_RST]) |=> (!cmdStart && !irq)); // R12

  AST_REVISION_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFF_REV)) |-> (regRdata == REV_VALUE)); // R13
endmodule

bind sdcmd_host sdcmd_host_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .irq      (irq),
  .cmdStart (cmdStart),
  .cmdIndex (cmdIndex),
  .cmdArg   (cmdArg)
);

// File: tb/sdcmd_host_test.sv
`timescale 1ns/1ps
module sdcmd_host_test;
  localparam int TO = 64;
  localparam logic [7:0] A_STAT = 8'h00, A_CLR = 8'h04, A_IEN = 8'h08, A_CMD = 8'h0C,
    A_ARG = 8'h10, A_RIDX = 8'h14, A_RSP0 = 8'h18, A_RSP1 = 8'h1C, A_RSP2 = 8'h20,
    A_RSP3 = 8'h24, A_DCTL = 8'h28, A_DLEN = 8'h2C, A_PWR = 8'h30, A_CLK = 8'h34,
    A_BUS = 8'h38, A_FIFO = 8'h3C, A_REV = 8'h40;

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0, cardDone = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [31:0] regWdata = '0, regRdata, cmdArg;
  logic [1:0] cardRspLen = 2'd0;
  logic [127:0] cardRsp = '0;
  logic irq, cmdStart;
  logic [5:0] cmdIndex;

  int checks = 0, fails = 0, cycles = 0, startCount = 0;
  logic [5:0] lastIdx = '0;
  logic [31:0] lastArg = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdcmd_host #(.ADDR_W(8), .TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .cmdStart(cmdStart), .cmdIndex(cmdIndex),
    .cmdArg(cmdArg), .cardDone(cardDone), .cardRspLen(cardRspLen), .cardRsp(cardRsp));

  // Behavioural reference model, advanced on every rising edge.
  logic [31:0] mCmd, mArg, mRidx, mDctl, mDlen, mIen, mPwr, mClk, mStat, mArgL, setB;
  logic [31:0] mRsp [4];
  logic [5:0] mIdx;
  logic mBusy, mExp, mLong, mApp, mStart, softR, wasBusy;
  int mCnt;

  function automatic logic [31:0] mRead(input logic [7:0] a);
    case (a)
      A_STAT: return mStat;  A_IEN: return mIen;   A_CMD: return mCmd;
      A_ARG: return mArg;    A_RIDX: return mRidx; A_RSP0: return mRsp[0];
      A_RSP1: return mRsp[1]; A_RSP2: return mRsp[2]; A_RSP3: return mRsp[3];
      A_DCTL: return mDctl;  A_DLEN: return mDlen; A_PWR: return mPwr;
      A_CLK: return mClk;    A_BUS: return 32'h9; A_FIFO: return 32'h10;
      A_REV: return 32'h0003_0300;
      default: return 32'h0;
    endcase
  endfunction

  task automatic softClear();
    mCmd = 0; mArg = 0; mRidx = 0; mDctl = 0; mDlen = 0; mIen = 0; mPwr = 0; mClk = 0;
    for (int i = 0; i < 4; i++) mRsp[i] = 0;
    mBusy = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      softClear();
      mStat = 32'h300; mStart = 0; mIdx = 0; mArgL = 0; mExp = 0; mLong = 0; mApp = 0; mCnt = 0;
    end else begin
      setB = 0;
      softR = regWr && regAddr == A_CMD && regWdata[10];
      wasBusy = mBusy;
      mStart = 0;
      if (mBusy && !softR) begin
        if (cardDone) begin
          mBusy = 0;
          if (!mExp) setB = 32'h40;
          else if (cardRspLen == 0 || cardRspLen == 3 || (cardRspLen == 1 && mLong)) setB = 32'h4;
          else begin
            setB = 32'h10;
            mRidx = {25'd0, mApp, mIdx};
            if (cardRspLen == 2) begin
              mRsp[3] = cardRsp[127:96]; mRsp[2] = cardRsp[95:64];
              mRsp[1] = cardRsp[63:32];  mRsp[0] = cardRsp[31:0] & ~32'h1;
            end else begin
              mRsp[0] = cardRsp[127:96]; mRsp[1] = 0; mRsp[2] = 0; mRsp[3] = 0;
            end
          end
        end else if (mCnt == TO - 1) begin
          setB = 32'h4; mBusy = 0;
        end else mCnt++;
      end
      if (regWr) begin
        case (regAddr)
          A_CMD: if (softR) begin
                   softClear();
                   mStat = (mStat & ~32'h1800) | 32'h300;
                 end else begin
                   mCmd = regWdata & ~32'h200;
                   if (regWdata[9] && !wasBusy) begin
                     mStat = mStat & ~32'h54; mBusy = 1; mCnt = 0; mStart = 1;
                     mIdx = regWdata[5:0]; mArgL = mArg;
                     mExp = regWdata[6]; mLong = regWdata[7]; mApp = regWdata[8];
                   end
                 end
          A_CLR:  mStat = mStat & ~(regWdata & 32'h14FF);
          A_IEN:  mIen = regWdata;
          A_ARG:  mArg = regWdata;
          A_DCTL: mDctl = regWdata;
          A_DLEN: mDlen = regWdata;
          A_PWR:  mPwr = regWdata;
          A_CLK:  mClk = regWdata;
          default: ;
        endcase
      end
      mStat = mStat | setB;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Per-cycle comparison against the model, plus the watchdog.
  always @(posedge clk) begin
    #3;
    cycles++;
    if (rstN) begin
      check("R11 irq vs model", {31'd0, irq}, {31'd0, |(mStat & mIen)});
      check("R1 cmdStart vs model", {31'd0, cmdStart}, {31'd0, mStart});
      check("R13 read data vs model", regRdata, mRead(regAddr));
      if (cmdStart) begin
        startCount++; lastIdx = cmdIndex; lastArg = cmdArg;
        check("R1 launched index", {26'd0, cmdIndex}, {26'd0, mIdx});
        check("R1 launched argument", cmdArg, mArgL);
      end
    end
    if (cycles > 20000 && !finished) begin
      fails++; checks++; finished = 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); regAddr = a;
    @(posedge clk); #3;
    check(tag, regRdata, exp);
  endtask

  task automatic reply(input logic [1:0] len, input logic [127:0] rsp);
    @(negedge clk); cardDone = 1; cardRspLen = len; cardRsp = rsp;
    @(negedge clk); cardDone = 0;
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    @(posedge clk); #3;
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  int s0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // Reset state and constants
    rd(A_STAT, 32'h300, "R12 status after reset");
    rd(A_CMD, 32'h0, "R12 command after reset");
    rd(A_BUS, 32'h9, "R13 bus capability");
    rd(A_FIFO, 32'h10, "R13 fifo depth");
    rd(A_REV, 32'h0003_0300, "R13 revision");
    rd(8'h80, 32'h0, "R13 undefined offset reads zero");
    // Plain storage
    wr(A_DCTL, 32'hA5A5_0F0F); rd(A_DCTL, 32'hA5A5_0F0F, "R14 data control");
    wr(A_DLEN, 32'h0000_0200); rd(A_DLEN, 32'h0000_0200, "R14 data length");
    wr(A_PWR, 32'hFFFF_FFFF);  rd(A_PWR, 32'hFFFF_FFFF, "R14 power");
    wr(A_CLK, 32'h1234_8001);  rd(A_CLK, 32'h1234_8001, "R14 clock");
    wr(8'h44, 32'hFFFF_FFFF); wr(A_REV, 32'h0); wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_REV, 32'h0003_0300, "R13 revision write ignored");
    rd(8'h44, 32'h0, "R13 undefined write ignored");
    rd(A_STAT, 32'h300, "R13 status not writable");
    // No-response command
    wr(A_ARG, 32'h1234_5678);
    s0 = startCount;
    wr(A_CMD, 32'h205);
    check("R1 one launch", startCount - s0, 1);
    check("R1 argument driven", lastArg, 32'h1234_5678);
    repeat (2) @(negedge clk);
    reply(2'd0, '0);
    rd(A_STAT, 32'h340, "R4 command-sent flag");
    rd(A_CMD, 32'h005, "R2 enable self-clears");
    // Short response, application command
    wr(A_ARG, 32'hCAFE_0001);
    wr(A_CMD, 32'h351);
    check("R1 index driven", {26'd0, lastIdx}, 32'd17);
    rd(A_STAT, 32'h300, "R2 launch clears bits 2/4/6");
    reply(2'd1, 128'hAABBCCDD_11111111_22222222_33333333);
    rd(A_RSP0, 32'hAABB_CCDD, "R5 short word0");
    rd(A_RSP1, 32'h0, "R5 short word1 zero");
    rd(A_RSP3, 32'h0, "R5 short word3 zero");
    rd(A_STAT, 32'h310, "R5 response flag");
    rd(A_RIDX, 32'h51, "R7 index and app flag");
    // Long response
    wr(A_CMD, 32'h2C2);
    reply(2'd2, 128'h01234567_89ABCDEF_FEDCBA98_76543211);
    rd(A_RSP3, 32'h0123_4567, "R6 long word3");
    rd(A_RSP2, 32'h89AB_CDEF, "R6 long word2");
    rd(A_RSP1, 32'hFEDC_BA98, "R6 long word1");
    rd(A_RSP0, 32'h7654_3210, "R6 long word0 bit0 cleared");
    rd(A_RIDX, 32'h02, "R7 index without app flag");
    // Error replies
    wr(A_CMD, 32'h2C3); reply(2'd1, {4{32'h5555_5555}});
    rd(A_STAT, 32'h304, "R8 short reply to long request");
    rd(A_RSP3, 32'h0123_4567, "R8 response kept");
    wr(A_CMD, 32'h244); reply(2'd3, {4{32'h6666_6666}});
    rd(A_STAT, 32'h304, "R8 malformed length");
    wr(A_CMD, 32'h245); reply(2'd0, '0);
    rd(A_STAT, 32'h304, "R8 no reply");
    rd(A_RIDX, 32'h02, "R8 log kept");
    // Long reply to a short request is stored as long
    wr(A_CMD, 32'h246); reply(2'd2, 128'h11112222_33334444_55556666_77778889);
    rd(A_RSP3, 32'h1111_2222, "R6 unrequested long word3");
    rd(A_RSP0, 32'h7777_8888, "R6 unrequested long word0");
    rd(A_STAT, 32'h310, "R6 unrequested long flag");
    // Timeout window
    wr(A_CMD, 32'h247);
    repeat (TO - 4) @(negedge clk);
    rd(A_STAT, 32'h300, "R9 still waiting inside window");
    repeat (8) @(negedge clk);
    rd(A_STAT, 32'h304, "R9 timeout flag");
    reply(2'd1, {4{32'h9999_9999}});
    rd(A_STAT, 32'h304, "R9 stale reply ignored");
    rd(A_RSP3, 32'h1111_2222, "R9 stale reply not stored");
    // Enable while outstanding
    s0 = startCount;
    wr(A_CMD, 32'h248);
    wr(A_CMD, 32'h249);
    check("R3 second enable launches nothing", startCount - s0, 1);
    rd(A_CMD, 32'h049, "R3 fields stored while outstanding");
    reply(2'd1, {32'hABCD_0001, 96'd0});
    rd(A_RIDX, 32'h08, "R3 original index logged");
    // Status clear
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h300, "R10 clear masks ready bits");
    wr(A_CMD, 32'h201);
    @(negedge clk); regWr = 1; regAddr = A_CLR; regWdata = 32'h40;
    cardDone = 1; cardRspLen = 2'd0;
    @(negedge clk); regWr = 0; cardDone = 0;
    rd(A_STAT, 32'h340, "R10 set wins over clear");
    wr(A_CLR, 32'h40);
    rd(A_STAT, 32'h300, "R10 selective clear");
    // Interrupt
    wr(A_IEN, 32'h10);
    chkIrq(1'b0, "R11 masked idle");
    wr(A_CMD, 32'h243); reply(2'd1, '0);
    chkIrq(1'b1, "R11 response raises irq");
    wr(A_CLR, 32'h10);
    chkIrq(1'b0, "R11 clear drops irq");
    wr(A_IEN, 32'h100);
    chkIrq(1'b1, "R11 ready bit raises irq");
    wr(A_IEN, 32'h0);
    chkIrq(1'b0, "R11 mask drops irq");
    // Soft reset during an outstanding command
    wr(A_PWR, 32'hF); wr(A_CLK, 32'h1FF); wr(A_DCTL, 32'h55); wr(A_DLEN, 32'h200);
    wr(A_IEN, 32'h4); wr(A_ARG, 32'hDEAD_BEEF);
    wr(A_CMD, 32'h245);
    s0 = startCount;
    wr(A_CMD, 32'h607);
    check("R12 soft reset launches nothing", startCount - s0, 0);
    rd(A_CMD, 32'h0, "R12 command zeroed");
    rd(A_ARG, 32'h0, "R12 argument zeroed");
    rd(A_PWR, 32'h0, "R12 power zeroed");
    rd(A_CLK, 32'h0, "R12 clock zeroed");
    rd(A_DCTL, 32'h0, "R12 data control zeroed");
    rd(A_DLEN, 32'h0, "R12 length zeroed");
    rd(A_IEN, 32'h0, "R12 enable zeroed");
    rd(A_RSP0, 32'h0, "R12 response zeroed");
    rd(A_RIDX, 32'h0, "R12 log zeroed");
    rd(A_STAT, 32'h300, "R12 status after soft reset");
    reply(2'd1, {4{32'h7777_7777}});
    rd(A_STAT, 32'h300, "R12 abandoned command ignores reply");
    rd(A_RSP0, 32'h0, "R12 abandoned reply not stored");
    wr(A_CMD, 32'h20A);
    check("R1 launch after soft reset", {26'd0, lastIdx}, 32'd10);
    reply(2'd0, '0);
    rd(A_STAT, 32'h340, "R4 sent after soft reset");
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule